// File: doc/BRIEF.md
# Byte-to-Word Receive Buffer Writer

This block takes bytes from a small receive byte queue and packs them into 32-bit words. It writes the words into a circular region of a shared SRAM through a request/grant port. Each write carries a byte mask, so only the lanes that hold new bytes are changed. A write pointer with an extra phase bit gives the buffer slot. Comparing that pointer with a read pointer supplied by software tells the block when the buffer is full. The wrap point is a programmable last index, so the depth does not have to be a power of two.

When bytes stop arriving in the middle of a word, a reloadable countdown timer forces the partial word out under a partial mask. The pointer stays where it is in that case. The next bytes fill the remaining lanes and are written to the same address, so the word is built up in SRAM over several writes. The block only consumes bytes while the mode input selects firmware mode.

Top module: `rx_sram_writer`

## Requirements
- R1: In reset and right after it, `sram_req_o` and `fifo_pop_o` are 0, `wptr_o` is 0 and `full_o` is 0.
- R2: Bytes are consumed only while `mode_i` equals the firmware-mode code 2'b10. With any other code, queued bytes stay in the byte queue and no SRAM write is issued.
- R3: Bytes are packed little-endian. The byte in lane n sits in `sram_wdata_o[8n+7:8n]`. Lane numbers run 0 to 3 and carry over from one write to the next. The first byte after reset goes into lane 0.
- R4: When a byte lands in lane 3, the word is written at address `base_i` plus the index field of the write pointer. The mask covers every lane filled since the previous write, which is all ones (32'hFFFF_FFFF) for a word filled from lane 0. After this write the pointer advances.
- R5: The byte queue may stay empty after a byte that did not fill lane 3. Once `timeout_i` cycles have counted down, the partial word is written with a mask covering only the lanes filled since the previous write, and the pointer does not move. Later bytes keep filling lanes at the same address.
- R6: A byte that arrives before the timer expires joins the pending word and does not cause a separate write. Each consumed byte reloads the timer.
- R7: `sram_req_o` stays high until `sram_gnt_i` is seen. While it waits, `sram_addr_o`, `sram_wdata_o` and `sram_wmask_o` are held stable, and the mask is never zero.
- R8: `wptr_o` is {phase, index}. When the index equals `limit_i`, an advance sets it to 0 and toggles the phase bit. Otherwise the index increments.
- R9: Subtract `rptr_i` from `wptr_o`. `full_o` is 1 exactly when the difference has its top bit set and its index bits zero. While full, no byte is consumed. Consumption resumes once `rptr_i` moves.
- R10: `fifo_pop_o` is only asserted while `fifo_valid_i` is high, and pops exactly one byte per cycle it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | Operating mode; 2'b10 enables the block |
| fifo_valid_i | input | 1 | Byte queue holds a byte |
| fifo_data_i | input | 8 | Byte at the head of the queue |
| fifo_pop_o | output | 1 | Consume the head byte this cycle |
| base_i | input | 10 | SRAM address of buffer slot 0 |
| limit_i | input | 4 | Last valid slot index before wrap |
| rptr_i | input | 5 | Software read pointer {phase, index} |
| timeout_i | input | 8 | Idle cycles before a partial word is flushed |
| sram_req_o | output | 1 | SRAM write request |
| sram_gnt_i | input | 1 | SRAM grant |
| sram_addr_o | output | 10 | SRAM word address |
| sram_wdata_o | output | 32 | SRAM write data |
| sram_wmask_o | output | 32 | SRAM bit write mask |
| wptr_o | output | 5 | Write pointer {phase, index} |
| full_o | output | 1 | Buffer full |

## Verification
The bench targets a word finished across two writes. The first write is a timeout flush of lanes 0 and 1. The second fills lanes 2 and 3 at the same address. A design that moved the pointer on the flush, or restarted lane numbering after it, would show a wrong address or a wrong mask in that second write. The bench also wraps the pointer at a limit of 3 and then holds bytes back while full, so that a bad phase toggle or a bad full comparison shows up as bytes popped into an occupied slot. Two further stimuli check the gating and merge rules. Bytes that arrive a few cycles apart must merge into one masked write, and bytes queued while the mode input is off must stay untouched.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_POP    = 3'd1,
    ST_WAIT   = 3'd2,
    ST_WRITE  = 3'd3,
    ST_UPDATE = 3'd4
  } rxw_state_e;
endpackage

// File: rtl/rxw_packer.sv
// Byte lane packer: collects bytes into a word and tracks which lanes are new.
module rxw_packer #(
  parameter int BYTE_W = 8,
  parameter int BYTES  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load_i,
  input  logic [BYTE_W-1:0]         byte_i,
  input  logic                      clr_i,
  output logic [BYTE_W*BYTES-1:0]   word_o,
  output logic [BYTE_W*BYTES-1:0]   mask_o,
  output logic                      last_o,
  output logic                      done_o
);
  localparam int WORD_W = BYTE_W * BYTES;
  localparam int POS_W  = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(BYTES - 1);

  logic [POS_W-1:0] pos_q;
  logic [BYTES-1:0] strb_q;
  logic [WORD_W-1:0] word_q;
  logic              done_q;

  assign last_o = (pos_q == LAST_POS);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      strb_q <= '0;
      done_q <= 1'b0;
      word_q <= '0;
    end else if (load_i) begin
      for (int i = 0; i < BYTES; i++) begin
        if (pos_q == POS_W'(i)) begin
          word_q[i*BYTE_W +: BYTE_W] <= byte_i;
          strb_q[i]                  <= 1'b1;
        end
      end
      pos_q <= last_o ? '0 : pos_q + 1'b1;
      if (last_o) done_q <= 1'b1;
    end else if (clr_i) begin
      strb_q <= '0;
      done_q <= 1'b0;
    end
  end

  logic [WORD_W-1:0] lane_mask;
  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign lane_mask[g*BYTE_W +: BYTE_W] = {BYTE_W{strb_q[g]}};
  end

  assign mask_o = (strb_q == '0) ? '1 : lane_mask;
  assign word_o = word_q;
  assign done_o = done_q;
endmodule

// File: rtl/rxw_timer.sv
// Reloadable countdown that saturates at zero.
module rxw_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [TMR_W-1:0] reload_i,
  output logic             expired_o
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                        cnt_q <= '0;
    else if (load_i)                cnt_q <= reload_i;
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/rxw_wptr.sv
// Write pointer with phase bit, programmable wrap point and full compare.
module rxw_wptr #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_i,
  input  logic [IDX_W-1:0] limit_i,
  input  logic [IDX_W:0]   rptr_i,
  output logic [IDX_W:0]   wptr_o,
  output logic             full_o
);
  logic [IDX_W:0] wptr_q;
  logic [IDX_W:0] diff;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
    end else if (adv_i) begin
      if (wptr_q[IDX_W-1:0] == limit_i) begin
        wptr_q[IDX_W-1:0] <= '0;
        wptr_q[IDX_W]     <= ~wptr_q[IDX_W];
      end else begin
        wptr_q[IDX_W-1:0] <= wptr_q[IDX_W-1:0] + 1'b1;
      end
    end
  end

  assign diff   = wptr_q - rptr_i;
  assign full_o = diff[IDX_W] && (diff[IDX_W-1:0] == '0);
  assign wptr_o = wptr_q;
endmodule

// File: rtl/rx_sram_writer.sv
module rx_sram_writer #(
  parameter int BYTE_W = 8,
  parameter int BYTES  = 4,
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 10,
  parameter int TMR_W  = 8,
  parameter int MODE_W = 2,
  parameter logic [MODE_W-1:0] FW_MODE = MODE_W'(2)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [MODE_W-1:0]         mode_i,
  input  logic                      fifo_valid_i,
  input  logic [BYTE_W-1:0]         fifo_data_i,
  output logic                      fifo_pop_o,
  input  logic [ADDR_W-1:0]         base_i,
  input  logic [IDX_W-1:0]          limit_i,
  input  logic [IDX_W:0]            rptr_i,
  input  logic [TMR_W-1:0]          timeout_i,
  output logic                      sram_req_o,
  input  logic                      sram_gnt_i,
  output logic [ADDR_W-1:0]         sram_addr_o,
  output logic [BYTE_W*BYTES-1:0]   sram_wdata_o,
  output logic [BYTE_W*BYTES-1:0]   sram_wmask_o,
  output logic [IDX_W:0]            wptr_o,
  output logic                      full_o
);
  import rxw_pkg::*;

  localparam int WORD_W = BYTE_W * BYTES;

  rxw_state_e st, st_nxt;
  logic active, last_lane, word_done, expired;
  logic [WORD_W-1:0] word, mask;

  assign active = (mode_i == FW_MODE);

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nxt;
  end

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_IDLE:   if (active && fifo_valid_i && !full_o) st_nxt = ST_POP;
      ST_POP:    st_nxt = last_lane ? ST_WRITE : ST_WAIT;
      ST_WAIT: begin
        if (fifo_valid_i) st_nxt = ST_POP;
        else if (expired) st_nxt = ST_WRITE;
      end
      ST_WRITE:  if (sram_gnt_i) st_nxt = ST_UPDATE;
      ST_UPDATE: st_nxt = ST_IDLE;
      default:   st_nxt = ST_IDLE;
    endcase
  end

  rxw_packer #(.BYTE_W(BYTE_W), .BYTES(BYTES)) u_pack (
    .clk    (clk),
    .rst    (rst),
    .load_i (st == ST_POP),
    .byte_i (fifo_data_i),
    .clr_i  (st == ST_UPDATE),
    .word_o (word),
    .mask_o (mask),
    .last_o (last_lane),
    .done_o (word_done)
  );

  rxw_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .load_i    (st == ST_POP),
    .run_i     (st == ST_WAIT),
    .reload_i  (timeout_i),
    .expired_o (expired)
  );

  rxw_wptr #(.IDX_W(IDX_W)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .adv_i   ((st == ST_UPDATE) && word_done),
    .limit_i (limit_i),
    .rptr_i  (rptr_i),
    .wptr_o  (wptr_o),
    .full_o  (full_o)
  );

  assign fifo_pop_o   = (st == ST_POP);
  assign sram_req_o   = (st == ST_WRITE);
  assign sram_addr_o  = base_i + ADDR_W'(wptr_o[IDX_W-1:0]);
  assign sram_wdata_o = word;
  assign sram_wmask_o = mask;
endmodule

// File: rtl/rxw_checker.sv
module rxw_checker #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 4,
  parameter int MODE_W = 2,
  parameter logic [MODE_W-1:0] FW_MODE = MODE_W'(2)
) (
  input logic                clk,
  input logic                rst,
  input logic [MODE_W-1:0]   mode_i,
  input logic                fifo_valid_i,
  input logic                fifo_pop_o,
  input logic                sram_req_o,
  input logic                sram_gnt_i,
  input logic [ADDR_W-1:0]   sram_addr_o,
  input logic [WORD_W-1:0]   sram_wdata_o,
  input logic [WORD_W-1:0]   sram_wmask_o,
  input logic [IDX_W:0]      wptr_o,
  input logic                full_o,
  input rxw_pkg::rxw_state_e st
);
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sram_req_o && !sram_gnt_i) |=> (sram_req_o && $stable(sram_addr_o)
      && $stable(sram_wdata_o) && $stable(sram_wmask_o)));

  // R7
  mask_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    sram_req_o |-> (sram_wmask_o != '0));

  // R10
  pop_valid_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_pop_o |-> fifo_valid_i);

  // R2
  inactive_chk: assert property (@(posedge clk) disable iff (rst)
    (st == rxw_pkg::ST_IDLE && mode_i != FW_MODE) |=> !fifo_pop_o);

  // R9
  full_block_chk: assert property (@(posedge clk) disable iff (rst)
    (st == rxw_pkg::ST_IDLE && full_o) |=> !fifo_pop_o);

  // R4
  ptr_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(wptr_o) |-> $past(sram_req_o && sram_gnt_i, 2));
endmodule

bind rx_sram_writer rxw_checker #(
  .WORD_W (BYTE_W * BYTES),
  .ADDR_W (ADDR_W),
  .IDX_W  (IDX_W),
  .MODE_W (MODE_W),
  .FW_MODE(FW_MODE)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .mode_i       (mode_i),
  .fifo_valid_i (fifo_valid_i),
  .fifo_pop_o   (fifo_pop_o),
  .sram_req_o   (sram_req_o),
  .sram_gnt_i   (sram_gnt_i),
  .sram_addr_o  (sram_addr_o),
  .sram_wdata_o (sram_wdata_o),
  .sram_wmask_o (sram_wmask_o),
  .wptr_o       (wptr_o),
  .full_o       (full_o),
  .st           (st)
);

// File: tb/rx_sram_writer_tb.sv
module rx_sram_writer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int GNT_LAT    = 2;
  localparam logic [9:0] BASE = 10'h100;

  typedef struct {
    logic [9:0]  addr;
    logic [31:0] data;
    logic [31:0] mask;
  } wr_item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'b10;
  logic        fifo_valid = 1'b0;
  logic [7:0]  fifo_data = '0;
  logic        fifo_pop;
  logic [3:0]  limit = 4'd3;
  logic [4:0]  rptr = '0;
  logic [7:0]  timeout = 8'd8;
  logic        req, gnt = 1'b0;
  logic [9:0]  addr;
  logic [31:0] wdata, wmask;
  logic [4:0]  wptr;
  logic        full;

  int checks = 0, failures = 0, wr_count = 0, gnt_cnt = 0;
  logic [7:0] byte_q[$];
  wr_item_t   exp_q[$];
  logic       pop_seen = 1'b0;

  // bench model of the packing and pointer rules
  logic [31:0] m_word = '0;
  logic [3:0]  m_strb = '0;
  int          m_pos = 0;
  logic [3:0]  m_idx = '0;
  logic        m_phase = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_sram_writer u_dut (
    .clk(clk), .rst(rst), .mode_i(mode), .fifo_valid_i(fifo_valid),
    .fifo_data_i(fifo_data), .fifo_pop_o(fifo_pop), .base_i(BASE),
    .limit_i(limit), .rptr_i(rptr), .timeout_i(timeout),
    .sram_req_o(req), .sram_gnt_i(gnt), .sram_addr_o(addr),
    .sram_wdata_o(wdata), .sram_wmask_o(wmask), .wptr_o(wptr), .full_o(full)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] strb2mask(input logic [3:0] s);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{s[i]}};
    return m;
  endfunction

  function automatic wr_item_t mk_item();
    wr_item_t it;
    it.addr = BASE + 10'(m_idx);
    it.data = m_word;
    it.mask = strb2mask(m_strb);
    return it;
  endfunction

  // driver: queue a byte and the write it is expected to produce (R3, R4, R8)
  task automatic send_byte(input logic [7:0] b);
    m_word[m_pos*8 +: 8] = b;
    m_strb[m_pos] = 1'b1;
    if (m_pos == 3) begin
      exp_q.push_back(mk_item());
      m_strb = '0;
      m_pos = 0;
      if (m_idx == limit) begin m_idx = '0; m_phase = ~m_phase; end
      else m_idx = m_idx + 1'b1;
    end else begin
      m_pos++;
    end
    byte_q.push_back(b);
  endtask

  // expected timeout flush of the pending lanes (R5)
  task automatic expect_flush();
    exp_q.push_back(mk_item());
    m_strb = '0;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // byte queue model, SRAM grant model and scoreboard monitor
  always @(negedge clk) begin
    if (pop_seen && byte_q.size() > 0) byte_q.delete(0);
    pop_seen = fifo_pop;
    fifo_valid = (byte_q.size() > 0);
    fifo_data  = (byte_q.size() > 0) ? byte_q[0] : 8'h00;
    gnt = req && (gnt_cnt == GNT_LAT);
    if (req && gnt) begin
      wr_item_t e;
      wr_count++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected write", 64'(addr), 64'h0);
      end else begin
        e = exp_q.pop_front();
        chk(addr == e.addr, "R4/R8 address", 64'(addr), 64'(e.addr));
        chk(wmask == e.mask, "R4/R5 mask", 64'(wmask), 64'(e.mask));
        chk((wdata & e.mask) == (e.data & e.mask), "R3 data",
            64'(wdata & e.mask), 64'(e.data & e.mask));
      end
    end
  end

  always @(posedge clk) begin
    if (req && gnt) gnt_cnt <= 0;
    else if (req)   gnt_cnt <= gnt_cnt + 1;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    int n0;
    wait_cycles(4);
    // R1 reset state
    chk(!req && !fifo_pop, "R1 req/pop in reset", {req, fifo_pop}, 0);
    chk(wptr == 0 && !full, "R1 pointer in reset", {wptr, full}, 0);
    rst = 1'b0;
    wait_cycles(2);
    chk(!req && !fifo_pop && wptr == 0 && !full, "R1 after reset",
        {req, fifo_pop, wptr, full}, 0);

    // R3 R4: one full word, then two back to back
    for (int i = 0; i < 4; i++) send_byte(8'h10 + 8'(i));
    wait_cycles(40);
    for (int i = 0; i < 8; i++) send_byte(8'hA0 + 8'(i));
    wait_cycles(80);
    chk(wr_count == 3, "R4 three word writes", wr_count, 3);
    chk(wptr == 5'd3, "R8 pointer after three words", wptr, 3);

    // R5: partial flush, pointer held, then completion at same address
    send_byte(8'h55); send_byte(8'h66);
    expect_flush();
    wait_cycles(50);
    chk(wr_count == 4, "R5 flush write issued", wr_count, 4);
    chk(wptr == 5'd3, "R5 pointer unchanged by flush", wptr, 3);
    send_byte(8'h77); send_byte(8'h88);
    wait_cycles(40);

    // R8 R9: wrap at limit 3 toggles phase and fills the buffer
    chk(wptr == 5'b10000, "R8 wrap with phase toggle", wptr, 5'b10000);
    chk(full == 1'b1, "R9 full after wrap", full, 1);
    n0 = wr_count;
    for (int i = 0; i < 4; i++) send_byte(8'hC0 + 8'(i));
    wait_cycles(50);
    chk(wr_count == n0, "R9 no write while full", wr_count, n0);
    chk(byte_q.size() == 4, "R9 bytes held while full", byte_q.size(), 4);
    rptr = 5'b10000;
    wait_cycles(50);
    chk(byte_q.size() == 0, "R9 drain after read pointer moves", byte_q.size(), 0);
    chk(!full && wptr == 5'b10001, "R9 not full after drain", {full, wptr}, 6'b010001);

    // R6: bytes a few cycles apart merge into one write
    n0 = wr_count;
    send_byte(8'h31);
    wait_cycles(3);
    send_byte(8'h32);
    expect_flush();
    wait_cycles(50);
    chk(wr_count == n0 + 1, "R6 single merged write", wr_count, n0 + 1);

    // R2: mode off holds bytes; mode on drains them
    mode = 2'b01;
    wait_cycles(2);
    n0 = wr_count;
    send_byte(8'h41); send_byte(8'h42);
    wait_cycles(50);
    chk(byte_q.size() == 2, "R2 no pop outside firmware mode", byte_q.size(), 2);
    chk(wr_count == n0, "R2 no write outside firmware mode", wr_count, n0);
    mode = 2'b10;
    wait_cycles(50);
    chk(byte_q.size() == 0, "R2 drain in firmware mode", byte_q.size(), 0);
    chk(wptr == 5'b10010, "R4 pointer after completed word", wptr, 5'b10010);

    // R10 and scoreboard completion
    chk(exp_q.size() == 0, "R10 every expected write seen", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule